// File: doc/BRIEF.md
# Lane-Partitioned Saturating Add/Subtract Unit

This unit adds or subtracts two 32-bit operands in signed arithmetic and clamps each result to the range its lane can represent. The 32-bit word is used in one of three ways: as one full-width lane, as two 16-bit lanes, or as four 8-bit lanes. Lane 0 always sits in the least significant bits. No carry or borrow ever crosses from one lane into the next. The packed result is a purely combinational function of the operands, the add/subtract select and the lane mode.

Next to the datapath sits a sticky saturation flag. Only a qualified full-width operation whose exact result falls outside the 32-bit signed range can raise it. The 16-bit and 8-bit lane modes clamp without ever touching it. An arithmetic operation never lowers the flag. Software-side control clears it, or loads any value into it, through a dedicated write port, and a write in the same cycle wins over an arithmetic set. The unit produces no other condition flags.

Top module: `lane_sat_alu`

## Requirements
- R1: `op_mode` encodes the lane layout: 0 gives one 32-bit lane, 1 gives two 16-bit lanes, 2 and 3 both give four 8-bit lanes. In 32-bit mode `result` is the clamped signed sum (or difference) of the full operands.
- R2: With `op_sub`=1 each lane of `result` is lane(`opnd_a`) minus the matching lane(`opnd_b`), clamped. With `op_sub`=0 it is the clamped sum.
- R3: In 16-bit mode, lane 0 is bits 15:0 and lane 1 is bits 31:16. Each lane is computed and clamped on its own, and no carry or borrow passes between the lanes.
- R4: In 8-bit mode, lane k is bits 8k+7:8k for k=0..3. Each lane is clamped on its own, with no carry or borrow between lanes.
- R5: A lane whose exact result is above 2^(n-1)-1 returns 2^(n-1)-1. A lane whose exact result is below -2^(n-1) returns -2^(n-1). Any other lane returns the exact result.
- R6: On a clock edge with `op_valid`=1, `op_mode`=0 and a full-width result that had to be clamped, `sat_flag` becomes 1. A valid full-width operation that did not clamp leaves the flag unchanged.
- R7: A valid operation in 16-bit or 8-bit mode never changes `sat_flag`, even when one of its lanes clamps.
- R8: On a clock edge with `flag_wr`=1, `sat_flag` takes the value of `flag_wr_val`. This write overrides a set from an arithmetic operation in the same cycle. Without a write, `sat_flag` never falls.
- R9: While `op_valid`=0, `sat_flag` does not change, whatever the operands are. `result` still reflects the current inputs.
- R10: A synchronous `rst`=1 sets `sat_flag` to 0 at the clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Qualifies the current operation for the flag update |
| op_sub | input | 1 | 0 = add, 1 = subtract (a minus b) |
| op_mode | input | 2 | Lane layout: 0 = 32-bit, 1 = 2x16-bit, 2/3 = 4x8-bit |
| opnd_a | input | 32 | First operand (minuend) |
| opnd_b | input | 32 | Second operand (subtrahend) |
| flag_wr | input | 1 | Explicit write of the sticky flag |
| flag_wr_val | input | 1 | Value loaded into the flag when `flag_wr` is 1 |
| result | output | 32 | Packed clamped lane results |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
The flag bit is the only stored state. If it is set wrongly, for example by a packed-mode clamp, by an unqualified operation, or by losing a write-over-set race, the error shows on `sat_flag` one cycle after the offending edge. It then persists, because no arithmetic path can clear it. Wrong lane splitting or a carry that leaks across a lane boundary shows on `result` in the same cycle. Operands that sit right at each lane's limits expose these faults, and the bench checks both outputs after every operation.

// File: rtl/lane_sat_pkg.sv
package lane_sat_pkg;

  typedef enum logic [1:0] {
    LM_W32    = 2'd0,
    LM_H16    = 2'd1,
    LM_B8     = 2'd2,
    LM_B8_ALT = 2'd3
  } lane_mode_e;

  localparam int unsigned NUM_LAYOUTS = 3;

endpackage

// File: rtl/lane_sat_slice.sv
module lane_sat_slice #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] res_o,
  output logic         sat_o
);

  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  // exact result at one extra bit of precision
  function automatic logic [W:0] wide_sum(input logic [W-1:0] a, input logic [W-1:0] b,
                                          input logic sub);
    logic [W:0] ea;
    logic [W:0] eb;
    ea = {a[W-1], a};
    eb = {b[W-1], b};
    return sub ? (ea - eb) : (ea + eb);
  endfunction

  function automatic logic [W-1:0] clamp(input logic [W:0] s);
    if (s[W] != s[W-1]) return s[W] ? MINV : MAXV;
    return s[W-1:0];
  endfunction

  logic [W:0] exact_w;
  logic       ovf_pos_w;
  logic       ovf_neg_w;

  assign exact_w   = wide_sum(a_i, b_i, sub_i);
  assign ovf_pos_w = ~exact_w[W] &  exact_w[W-1];
  assign ovf_neg_w =  exact_w[W] & ~exact_w[W-1];
  assign res_o     = clamp(exact_w);
  assign sat_o     = ovf_pos_w | ovf_neg_w;

  always_comb begin
    // R5
    if (ovf_pos_w) pos_clamp_chk: assert (res_o == MAXV);
    // R5
    if (ovf_neg_w) neg_clamp_chk: assert (res_o == MINV);
    // R5
    if (!sat_o) exact_pass_chk: assert ({res_o[W-1], res_o} == exact_w);
  end

endmodule

// File: rtl/lane_sat_group.sv
module lane_sat_group #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LANES  = 1
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] res_o,
  output logic              any_sat_o
);

  localparam int unsigned LW = DATA_W / LANES;

  logic [LANES-1:0] lane_sat_w;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lane_sat_slice #(.W(LW)) slice_i (
      .a_i   (a_i[g*LW +: LW]),
      .b_i   (b_i[g*LW +: LW]),
      .sub_i (sub_i),
      .res_o (res_o[g*LW +: LW]),
      .sat_o (lane_sat_w[g])
    );
  end

  assign any_sat_o = |lane_sat_w;

endmodule

// File: rtl/lane_sat_core.sv
module lane_sat_core
  import lane_sat_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  input  lane_mode_e        mode_i,
  output logic [DATA_W-1:0] res_o,
  output logic              full_sat_evt_o,
  output logic              packed_sat_evt_o
);

  // layout k splits the word into 2**k lanes
  logic [DATA_W-1:0] grp_res_w [NUM_LAYOUTS];
  logic              grp_sat_w [NUM_LAYOUTS];

  for (genvar k = 0; k < NUM_LAYOUTS; k++) begin : g_layout
    lane_sat_group #(.DATA_W(DATA_W), .LANES(1 << k)) grp_i (
      .a_i       (a_i),
      .b_i       (b_i),
      .sub_i     (sub_i),
      .res_o     (grp_res_w[k]),
      .any_sat_o (grp_sat_w[k])
    );
  end

  always_comb begin
    unique case (mode_i)
      LM_W32:  res_o = grp_res_w[0];
      LM_H16:  res_o = grp_res_w[1];
      default: res_o = grp_res_w[2];
    endcase
  end

  assign full_sat_evt_o   = grp_sat_w[0];
  assign packed_sat_evt_o = (mode_i == LM_H16) ? grp_sat_w[1] : grp_sat_w[2];

endmodule

// File: rtl/sat_sticky_flag.sv
module sat_sticky_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_evt_i,
  input  logic wr_en_i,
  input  logic wr_val_i,
  output logic flag_o
);

  always_ff @(posedge clk) begin
    if (rst)            flag_o <= 1'b0;
    else if (wr_en_i)   flag_o <= wr_val_i;
    else if (set_evt_i) flag_o <= 1'b1;
  end

  // R8
  wr_wins_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en_i |=> (flag_o == $past(wr_val_i)));
  // R8
  no_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_o && !wr_en_i) |=> flag_o);
  // R6
  set_takes_chk: assert property (@(posedge clk) disable iff (rst)
    (set_evt_i && !wr_en_i) |=> flag_o);
  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !flag_o);

endmodule

// File: rtl/lane_sat_alu.sv
module lane_sat_alu
  import lane_sat_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic              op_sub,
  input  logic [1:0]        op_mode,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic              flag_wr,
  input  logic              flag_wr_val,
  output logic [DATA_W-1:0] result,
  output logic              sat_flag
);

  lane_mode_e mode_w;
  logic       full_sat_evt_w;
  logic       packed_sat_evt_w;
  logic       flag_set_evt_w;

  assign mode_w = lane_mode_e'(op_mode);

  lane_sat_core #(.DATA_W(DATA_W)) core_i (
    .a_i              (opnd_a),
    .b_i              (opnd_b),
    .sub_i            (op_sub),
    .mode_i           (mode_w),
    .res_o            (result),
    .full_sat_evt_o   (full_sat_evt_w),
    .packed_sat_evt_o (packed_sat_evt_w)
  );

  assign flag_set_evt_w = op_valid && (mode_w == LM_W32) && full_sat_evt_w;

  sat_sticky_flag flag_i (
    .clk       (clk),
    .rst       (rst),
    .set_evt_i (flag_set_evt_w),
    .wr_en_i   (flag_wr),
    .wr_val_i  (flag_wr_val),
    .flag_o    (sat_flag)
  );

  // R7
  packed_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (mode_w != LM_W32) && packed_sat_evt_w && !flag_wr) |=> $stable(sat_flag));
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!op_valid && !flag_wr) |=> $stable(sat_flag));
  // R6
  full_nosat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (mode_w == LM_W32) && !full_sat_evt_w && !flag_wr) |=> $stable(sat_flag));

endmodule

// File: tb/lane_sat_alu_tb_top.sv
module lane_sat_alu_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid;
  logic        op_sub;
  logic [1:0]  op_mode;
  logic [31:0] opnd_a;
  logic [31:0] opnd_b;
  logic        flag_wr;
  logic        flag_wr_val;
  logic [31:0] result;
  logic        sat_flag;

  int n_cmp = 0;
  int n_bad = 0;
  bit model_flag = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lane_sat_alu dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_sub(op_sub), .op_mode(op_mode),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .flag_wr(flag_wr), .flag_wr_val(flag_wr_val),
    .result(result), .sat_flag(sat_flag)
  );

  // reference: per-lane exact arithmetic in 64-bit integers, then clamp
  function automatic logic [31:0] ref_calc(input logic [31:0] a, input logic [31:0] b,
                                           input bit sub, input logic [1:0] mode,
                                           output bit clamped_any);
    int    nl;
    int    w;
    logic [31:0] r;
    longint lo;
    longint hi;
    nl = (mode == 2'd0) ? 1 : (mode == 2'd1) ? 2 : 4;
    w  = 32 / nl;
    r  = '0;
    clamped_any = 1'b0;
    hi = (64'sd1 <<< (w - 1)) - 1;
    lo = -(64'sd1 <<< (w - 1));
    for (int i = 0; i < nl; i++) begin
      longint x;
      longint y;
      longint s;
      x = longint'((64'(a) >> (i * w)) & ((64'sd1 <<< w) - 1));
      y = longint'((64'(b) >> (i * w)) & ((64'sd1 <<< w) - 1));
      if (x > hi) x = x - (64'sd1 <<< w);
      if (y > hi) y = y - (64'sd1 <<< w);
      s = sub ? x - y : x + y;
      if (s > hi) begin s = hi; clamped_any = 1'b1; end
      if (s < lo) begin s = lo; clamped_any = 1'b1; end
      for (int k = 0; k < w; k++) r[i * w + k] = s[k];
    end
    return r;
  endfunction

  task automatic check_res(input string tag, input logic [31:0] exp_v);
    n_cmp++;
    if (result !== exp_v) begin
      n_bad++;
      $display("FAIL %s result actual=%08h expected=%08h", tag, result, exp_v);
    end
  endtask

  task automatic check_flag(input string tag);
    n_cmp++;
    if (sat_flag !== model_flag) begin
      n_bad++;
      $display("FAIL %s sat_flag actual=%0b expected=%0b", tag, sat_flag, model_flag);
    end
  endtask

  // drive at negedge, compare result before posedge, compare flag after it
  task automatic do_op(input bit v, input bit sub, input logic [1:0] mode,
                       input logic [31:0] a, input logic [31:0] b,
                       input bit wr, input bit wv, input string tag);
    logic [31:0] exp_r;
    bit cl;
    @(negedge clk);
    op_valid = v; op_sub = sub; op_mode = mode; opnd_a = a; opnd_b = b;
    flag_wr = wr; flag_wr_val = wv;
    exp_r = ref_calc(a, b, sub, mode, cl);
    #1;
    check_res(tag, exp_r);
    if (wr) model_flag = wv;
    else if (v && mode == 2'd0 && cl) model_flag = 1'b1;
    @(posedge clk);
    #1;
    check_flag(tag);
  endtask

  function automatic logic [31:0] pick_opnd();
    case ($urandom_range(0, 7))
      0: return 32'h7fff_ffff;
      1: return 32'h8000_0000;
      2: return 32'h7f7f_7f7f;
      3: return 32'h8080_8080;
      4: return 32'h7fff_8000;
      default: return $urandom;
    endcase
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; op_valid = 0; op_sub = 0; op_mode = 0; opnd_a = 0; opnd_b = 0;
    flag_wr = 0; flag_wr_val = 0;
    repeat (3) @(posedge clk);
    #1;
    model_flag = 1'b0;
    check_flag("R10 reset");
    @(negedge clk);
    rst = 1'b0;

    // R1/R5: full-width positive and negative clamp, flag set (R6)
    do_op(1, 0, 2'd0, 32'h7fff_ffff, 32'h0000_0001, 0, 0, "R1 R5 R6 pos");
    do_op(1, 0, 2'd0, 32'h0000_0005, 32'h0000_0003, 0, 0, "R6 keep");
    do_op(1, 0, 2'd0, 32'h0, 32'h0, 1, 0, "R8 clear");
    do_op(1, 1, 2'd0, 32'h8000_0000, 32'h0000_0001, 0, 0, "R2 R5 neg");
    do_op(1, 0, 2'd0, 32'h0, 32'h0, 1, 0, "R8 clear2");
    // R8: write beats arithmetic set in the same cycle
    do_op(1, 0, 2'd0, 32'h7fff_ffff, 32'h7fff_ffff, 1, 0, "R8 priority");
    do_op(0, 0, 2'd0, 32'h0, 32'h0, 1, 1, "R8 write one");
    do_op(0, 0, 2'd0, 32'h0, 32'h0, 1, 0, "R8 write zero");
    // R9: unqualified saturating op leaves flag, result still live
    do_op(0, 0, 2'd0, 32'h7fff_ffff, 32'h7fff_ffff, 0, 0, "R9 idle");
    // R3/R7: 16-bit lanes clamp silently, no carry between lanes
    do_op(1, 0, 2'd1, 32'h7fff_8000, 32'h0001_ffff, 0, 0, "R3 R7 h16");
    do_op(1, 0, 2'd1, 32'h0000_ffff, 32'h0000_0001, 0, 0, "R3 nocarry");
    do_op(1, 1, 2'd1, 32'h0000_0000, 32'h0000_0001, 0, 0, "R3 R2 noborrow");
    // R4/R7: 8-bit lanes, both encodings
    do_op(1, 1, 2'd2, 32'h8000_7f10, 32'h0180_8020, 0, 0, "R4 R7 b8");
    do_op(1, 0, 2'd3, 32'h7f80_00ff, 32'h0180_ff01, 0, 0, "R4 alt b8");
    // R10: reset clears a set flag
    do_op(1, 0, 2'd0, 32'h7fff_ffff, 32'h0000_0001, 0, 0, "R6 set again");
    @(negedge clk);
    rst = 1'b1; op_valid = 0; flag_wr = 0;
    @(posedge clk);
    #1;
    model_flag = 1'b0;
    check_flag("R10 reset set flag");
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < 2000; i++) begin
      bit wr;
      wr = ($urandom_range(0, 15) == 0);
      do_op($urandom_range(0, 3) != 0, $urandom_range(0, 1), 2'($urandom_range(0, 3)),
            pick_opnd(), pick_opnd(), wr, $urandom_range(0, 1), "R1-mix R2 R3 R4 R6 R7 R8 random");
    end
    finish_run();
  end

endmodule